// File: doc/BRIEF.md
# DMA Shared Operation Register

This block is the operation register that all channels of a four-channel DMA controller share. It holds three bits: a master enable and two sticky error flags. One flag records a DMA address error. The other records a non-maskable interrupt. From these bits, and from the enable (DE) and transfer-end (TE) bits of each channel's control register, it forms a per-channel enable vector. When the master enable is turned off, it sends a one-cycle abort pulse to every channel.

Software reaches the register through a plain strobe port. It can write the master enable at any time. It cannot set either flag. A flag clears only after a two-step handshake: first a read that sees the flag at 1, then a write of 0 to that bit. Each flag is run by its own three-state machine:

- `FLG_CLEAR`: the flag is 0.
- `FLG_PENDING`: the flag is 1 and has not been read.
- `FLG_ARMED`: the flag is 1 and has been read as 1.

The transitions are:

- set: any state to `FLG_PENDING`, on a hardware event.
- arm: `FLG_PENDING` to `FLG_ARMED`, on a read.
- release: `FLG_ARMED` to `FLG_CLEAR`, on a write of 0.
- drop: any state to `FLG_CLEAR`, on standby.

The master enable has its own two-state machine:

- `DME_OFF` to `DME_ON` on a write of 1.
- `DME_ON` to `DME_OFF` on a write of 0 or on standby. This transition raises the abort pulse.

Reset and standby both return every machine to its cleared state.

Top module: `dma_opreg_ctl`

## Requirements
- R1: Read data is combinational from the current state. Bit 0 is the master enable, bit 1 is the NMI flag and bit 2 is the address-error flag.
- R2: After reset all three bits read 0, every channel enable is 0 and the abort output is 0.
- R3: A write strobe loads write-data bit 0 into the master enable. The new value is visible in the cycle after the strobe. The enable can be set and cleared freely.
- R4: Channel k is enabled exactly when DE[k]=1, TE[k]=0, the master enable is 1, and both flags are 0. The enable is combinational from the inputs and the register state.
- R5: While either flag is 1, every channel enable is 0, whatever the DE, TE and master-enable values.
- R6: A pulse on the address-error input sets bit 2, and a pulse on the NMI input sets bit 1. Each takes effect in the next cycle.
- R7: Writing 1 to bit 1 or bit 2 never sets that flag.
- R8: A write of 0 clears a flag only if the flag was read while it was 1 earlier. A write of 0 without that read leaves the flag at 1.
- R9: If a hardware set and a clearing write arrive in the same cycle, the flag stays 1 and its armed state is dropped. A later write of 0 without a new read does not clear it.
- R10: When the master enable goes from 1 to 0, the abort output is 1 for exactly one cycle, in the cycle the enable first reads 0. At all other times it is 0.
- R11: While standby is high, all three bits are held at 0 and hardware set events are ignored. Any pending arm is lost.
- R12: A read while a flag is 0 does not arm it. If hardware later sets the flag, a write of 0 leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby mode, clears the register while high |
| rd_stb_i | input | 1 | Register read strobe |
| wr_stb_i | input | 1 | Register write strobe |
| wr_data_i | input | 3 | Write data, bit 0 enable, bit 1 NMI flag, bit 2 address-error flag |
| rd_data_o | output | 3 | Read data, same bit layout |
| addr_err_i | input | 1 | Address-error event from the transfer engine |
| nmi_i | input | 1 | NMI event |
| ch_de_i | input | NUM_CH | Per-channel DE bits |
| ch_te_i | input | NUM_CH | Per-channel TE bits |
| ch_en_o | output | NUM_CH | Per-channel transfer enable |
| abort_o | output | 1 | One-cycle abort to all channels |

## Verification
The bench sweeps all 256 DE/TE combinations under each of the eight register states. This catches a gate that ignores one of the vetoes or inverts TE. A design wrong here would enable a channel while a flag is up, or while its transfer has ended.

Beyond the sweep, the bench targets the clear handshake:

- A write of 0 without a prior read. A design that clears on any write of 0 would drop the flag.
- A read taken while the flag was still 0. A design that arms on that read would clear the flag too early.
- A set arriving together with a clearing write. A design that lets the clear win, or keeps the arm, would lose the event.

It also checks that the abort lasts exactly one cycle, and that standby overrides a set event arriving in the same cycle.

// File: rtl/dma_opreg_pkg.sv
package dma_opreg_pkg;
    localparam int REG_W    = 3;
    localparam int BIT_DME  = 0;
    localparam int BIT_NMIF = 1;
    localparam int BIT_AE   = 2;

    typedef enum logic [1:0] {
        FLG_CLEAR   = 2'd0,
        FLG_PENDING = 2'd1,
        FLG_ARMED   = 2'd2
    } flag_state_e;

    typedef enum logic {
        DME_OFF = 1'b0,
        DME_ON  = 1'b1
    } dme_state_e;
endpackage

// File: rtl/dma_flag_fsm.sv
module dma_flag_fsm
    import dma_opreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic hw_set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o,
    output logic armed_o
);
    flag_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    // next state: standby, then set, then clear, then arm
    always_comb begin
        state_d = state_q;
        if (standby_i) begin
            state_d = FLG_CLEAR;
        end else if (hw_set_i) begin
            state_d = FLG_PENDING;
        end else begin
            unique case (state_q)
                FLG_CLEAR:   state_d = FLG_CLEAR;
                FLG_PENDING: if (rd_i) state_d = FLG_ARMED;
                FLG_ARMED:   if (wr_i && !wr_bit_i) state_d = FLG_CLEAR;
                default:     state_d = FLG_CLEAR;
            endcase
        end
    end

    // outputs
    always_comb begin
        flag_o  = 1'b0;
        armed_o = 1'b0;
        unique case (state_q)
            FLG_CLEAR:   ;
            FLG_PENDING: flag_o = 1'b1;
            FLG_ARMED: begin
                flag_o  = 1'b1;
                armed_o = 1'b1;
            end
            default:     ;
        endcase
    end
endmodule

// File: rtl/dma_master_en.sv
module dma_master_en
    import dma_opreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic dme_o,
    output logic abort_o
);
    dme_state_e state_q, state_d;
    logic       abort_q;

    // state register and abort pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DME_OFF;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            abort_q <= (state_q == DME_ON) && (state_d == DME_OFF);
        end
    end

    always_comb begin
        state_d = state_q;
        if (standby_i) begin
            state_d = DME_OFF;
        end else begin
            unique case (state_q)
                DME_OFF: if (wr_i && wr_bit_i)  state_d = DME_ON;
                DME_ON:  if (wr_i && !wr_bit_i) state_d = DME_OFF;
                default: state_d = DME_OFF;
            endcase
        end
    end

    always_comb begin
        dme_o   = (state_q == DME_ON);
        abort_o = abort_q;
    end
endmodule

// File: rtl/dma_chan_gate.sv
module dma_chan_gate (
    input  logic go_i,
    input  logic de_i,
    input  logic te_i,
    output logic en_o
);
    always_comb en_o = go_i & de_i & ~te_i;
endmodule

// File: rtl/dma_opreg_ctl.sv
module dma_opreg_ctl
    import dma_opreg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              rd_stb_i,
    input  logic              wr_stb_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic              addr_err_i,
    input  logic              nmi_i,
    input  logic [NUM_CH-1:0] ch_de_i,
    input  logic [NUM_CH-1:0] ch_te_i,
    output logic [NUM_CH-1:0] ch_en_o,
    output logic              abort_o
);
    logic ae_flag, ae_armed, nmi_flag, nmi_armed, dme;
    logic go;

    dma_flag_fsm u_ae (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i),
        .hw_set_i(addr_err_i), .rd_i(rd_stb_i), .wr_i(wr_stb_i),
        .wr_bit_i(wr_data_i[BIT_AE]), .flag_o(ae_flag), .armed_o(ae_armed)
    );

    dma_flag_fsm u_nmi (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i),
        .hw_set_i(nmi_i), .rd_i(rd_stb_i), .wr_i(wr_stb_i),
        .wr_bit_i(wr_data_i[BIT_NMIF]), .flag_o(nmi_flag), .armed_o(nmi_armed)
    );

    dma_master_en u_dme (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i),
        .wr_i(wr_stb_i), .wr_bit_i(wr_data_i[BIT_DME]),
        .dme_o(dme), .abort_o(abort_o)
    );

    always_comb begin
        rd_data_o           = '0;
        rd_data_o[BIT_DME]  = dme;
        rd_data_o[BIT_NMIF] = nmi_flag;
        rd_data_o[BIT_AE]   = ae_flag;
        go                  = dme & ~ae_flag & ~nmi_flag;
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        dma_chan_gate u_gate (
            .go_i(go), .de_i(ch_de_i[k]), .te_i(ch_te_i[k]), .en_o(ch_en_o[k])
        );
    end
endmodule

// File: rtl/dma_opreg_chk.sv
module dma_opreg_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby_i,
    input logic              wr_stb_i,
    input logic [2:0]        wr_data_i,
    input logic [2:0]        rd_data_o,
    input logic              addr_err_i,
    input logic              nmi_i,
    input logic [NUM_CH-1:0] ch_en_o,
    input logic              abort_o
);
    // R5
    flag_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[1] || rd_data_o[2]) |-> (ch_en_o == '0));

    // R6
    ae_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_err_i && !standby_i) |=> rd_data_o[2]);

    // R6
    nmi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_i && !standby_i) |=> rd_data_o[1]);

    // R7
    no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data_o[2] && !addr_err_i) |=> !rd_data_o[2]);

    // R10
    abort_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (!rd_data_o[0] && $past(rd_data_o[0])));

    // R10
    abort_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    // R11
    standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (rd_data_o == 3'b000));

    // R3
    dme_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && !standby_i) |=> (rd_data_o[0] == $past(wr_data_i[0])));
endmodule

bind dma_opreg_ctl dma_opreg_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .wr_stb_i(wr_stb_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .addr_err_i(addr_err_i),
    .nmi_i(nmi_i), .ch_en_o(ch_en_o), .abort_o(abort_o)
);

// File: tb/dma_opreg_ctl_tb_top.sv
module dma_opreg_ctl_tb_top;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           standby = 1'b0, rd = 1'b0, wr = 1'b0, ae_ev = 1'b0, nmi_ev = 1'b0;
    logic [2:0]     wdata = '0;
    logic [2:0]     rdata;
    logic [NCH-1:0] de = '0, te = '0, en;
    logic           abort;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    dma_opreg_ctl #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .standby_i(standby), .rd_stb_i(rd),
        .wr_stb_i(wr), .wr_data_i(wdata), .rd_data_o(rdata),
        .addr_err_i(ae_ev), .nmi_i(nmi_ev), .ch_de_i(de), .ch_te_i(te),
        .ch_en_o(en), .abort_o(abort)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_wr(input logic [2:0] d);
        wr = 1'b1; wdata = d; step(); wr = 1'b0; wdata = '0;
    endtask

    task automatic do_rd();
        rd = 1'b1; step(); rd = 1'b0;
    endtask

    task automatic pulse_ae();
        ae_ev = 1'b1; step(); ae_ev = 1'b0;
    endtask

    task automatic pulse_nmi();
        nmi_ev = 1'b1; step(); nmi_ev = 1'b0;
    endtask

    task automatic load_state(input bit d, input bit n, input bit a);
        standby = 1'b1; step(); standby = 1'b0;
        if (n) pulse_nmi();
        if (a) pulse_ae();
        if (d) do_wr(3'b111);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R2
        check("R2 rd", int'(rdata), 0);
        check("R2 en", int'(en), 0);
        check("R2 abort", int'(abort), 0);

        // R3 / R1: enable written freely, bit 0
        do_wr(3'b001);
        check("R3 set", int'(rdata), 1);
        check("R10 no abort on rise", int'(abort), 0);
        do_wr(3'b000);
        check("R3 clear", int'(rdata), 0);
        check("R10 abort", int'(abort), 1);
        step();
        check("R10 one cycle", int'(abort), 0);

        // R7: writing 1 to flags does not set them
        do_wr(3'b110);
        check("R7", int'(rdata), 0);

        // R6 / R1 bit positions
        pulse_ae();
        check("R6 ae bit2", int'(rdata), 4);
        pulse_nmi();
        check("R6 nmi bit1", int'(rdata), 6);

        // R8: write 0 without read keeps flag
        do_wr(3'b000);
        check("R8 no read", int'(rdata), 6);
        do_rd();
        do_wr(3'b010);
        check("R8 clear ae only", int'(rdata), 2);
        do_wr(3'b000);
        check("R8 clear nmi", int'(rdata), 0);

        // R9: set and clear same cycle
        pulse_ae(); do_rd();
        ae_ev = 1'b1; wr = 1'b1; wdata = 3'b000; step();
        ae_ev = 1'b0; wr = 1'b0;
        check("R9 set wins", int'(rdata[2]), 1);
        do_wr(3'b000);
        check("R9 arm dropped", int'(rdata[2]), 1);
        do_rd(); do_wr(3'b000);
        check("R9 rearm clears", int'(rdata[2]), 0);

        // R12: read while 0 does not arm
        do_rd(); pulse_nmi(); do_wr(3'b000);
        check("R12", int'(rdata[1]), 1);

        // R11: standby clears, overrides set, loses arm, aborts DME
        do_wr(3'b111);
        check("R11 pre", int'(rdata), 3);
        do_rd();
        standby = 1'b1; ae_ev = 1'b1; step();
        check("R11 held", int'(rdata), 0);
        check("R10 standby abort", int'(abort), 1);
        step();
        check("R11 still held", int'(rdata), 0);
        standby = 1'b0; ae_ev = 1'b0; step();
        check("R11 released", int'(rdata), 0);
        pulse_nmi(); do_wr(3'b000);
        check("R11 arm lost", int'(rdata[1]), 1);

        // R4 / R5 sweep over all states and DE/TE combos
        for (int s = 0; s < 8; s++) begin
            load_state(s[0], s[1], s[2]);
            for (int v = 0; v < 256; v++) begin
                de = v[3:0]; te = v[7:4];
                #1;
                begin
                    logic [NCH-1:0] exp_en;
                    exp_en = (s == 1) ? (de & ~te) : '0;
                    check((s == 1) ? "R4 gate" : "R5 veto", int'(en), int'(exp_en));
                end
            end
            de = '0; te = '0;
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule